// File: doc/BRIEF.md
# Frequency Multiplier Control Register

This block is the control and status word for a clock multiplier. Software writes one 32-bit word that holds an enable bit, a six-bit multiplier code and a two-bit reference index. The block decodes that word into the effective multiplication factor and the active reference index, which go to the clock generation logic. When the multiplier is off, the factor is one and the clock passes straight through from the chosen reference. When it is on, the factor is twice the code plus two.

The block checks each write before it takes effect. A write is dropped as a whole when its code falls outside the legal band, when it names an undefined reference, or when it changes the code while the multiplier is running and the enable bit stays set. A dropped write sets a sticky error flag, and a read clears that flag. Software must therefore turn the multiplier off before it retunes it.

A lock-ready flag models the settling time. It rises a fixed, parameterised number of cycles after the multiplier is switched on. It falls at once when the multiplier is switched off. Moving to another reference while the multiplier runs starts the settling time again.

Top module: `pll_ctrl_reg`

## Requirements
- R1: After reset the multiplier is off, the code is 19, the reference index is 0, ready is low and the error flag is clear, so a read returns 0x1300_0000.
- R2: While the enable bit (bit 31) is clear, the factor output is 1 and the reference output follows bits 7:6.
- R3: While the enable bit is set, the factor output equals (code + 1) * 2, where the code sits in bits 29:24.
- R4: A write whose code is below 19 or above 45 leaves the whole configuration unchanged and sets the error flag.
- R5: A write whose reference index (bits 7:6) is 3 leaves the configuration unchanged and sets the error flag.
- R6: While the multiplier is on, a write that keeps the enable bit set and carries a different code is dropped and sets the error flag. A write that clears the enable bit may carry a new code at the same time.
- R7: The error flag is bit 0 of the read word. A read returns the flag and clears it. A dropped write in the same cycle as a read leaves the flag set.
- R8: A read strobe loads the read register on that clock edge. The value is available from then on, with bit 31 enable, bits 29:24 code, bits 7:6 reference, bit 1 ready and bit 0 error, and all other bits zero. The value reflects the state before any write accepted on the same edge.
- R9: Ready rises exactly LOCK_CYCLES clock edges after the edge that accepts a write turning the multiplier on.
- R10: Ready falls on the same edge that accepts a write clearing the enable bit.
- R11: An accepted write that changes the reference while the multiplier stays on drops ready on that edge. It restarts the full LOCK_CYCLES wait. A write that keeps the same reference and code leaves ready as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wdata | input | 32 | Control word to write |
| rd_en | input | 1 | Read strobe; loads rdata and clears the error flag |
| rdata | output | 32 | Registered read word |
| pll_on | output | 1 | Multiplier enabled |
| mult_factor | output | 7 | Effective multiplication factor (1 when bypassed) |
| ref_sel | output | 2 | Active reference index |
| lock_ready | output | 1 | Settling time elapsed since the last start |

## Verification
The bench builds the block with LOCK_CYCLES set to 5. With that value the exact rising edge of ready can be checked, both from a cold start and after a reference change: the bench samples once on the edge before the expected edge and once on that edge, within a few cycles. The code limits keep their defaults of 19 and 45. This puts both legal end points and the illegal codes next to them on the edge of the accept logic. The bench also covers a read that collides with a rejected write.

// File: rtl/pllc_pkg.sv
package pllc_pkg;

    localparam int CODE_W   = 6;
    localparam int SEL_W    = 2;
    localparam int WORD_W   = 32;

    localparam int EN_BIT   = 31;
    localparam int CODE_LSB = 24;
    localparam int SEL_LSB  = 6;
    localparam int RDY_BIT  = 1;
    localparam int ERR_BIT  = 0;

    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] code;
        logic [SEL_W-1:0]  sel;
    } pllc_cfg_t;

    function automatic pllc_cfg_t unpack_word(input logic [WORD_W-1:0] w);
        pllc_cfg_t c;
        c.en   = w[EN_BIT];
        c.code = w[CODE_LSB +: CODE_W];
        c.sel  = w[SEL_LSB +: SEL_W];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input pllc_cfg_t c,
                                                    input logic rdy,
                                                    input logic err);
        logic [WORD_W-1:0] w;
        w = '0;
        w[EN_BIT]               = c.en;
        w[CODE_LSB +: CODE_W]   = c.code;
        w[SEL_LSB +: SEL_W]     = c.sel;
        w[RDY_BIT]              = rdy;
        w[ERR_BIT]              = err;
        return w;
    endfunction

endpackage

// File: rtl/pllc_regfile.sv
module pllc_regfile
    import pllc_pkg::*;
#(
    parameter int CODE_MIN   = 19,
    parameter int CODE_MAX   = 45,
    parameter int NUM_SRC    = 3,
    parameter int RESET_CODE = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rd_en,
    output pllc_cfg_t         cfg_q,
    output logic              en_nxt,
    output logic              restart,
    output logic              err_q
);

    localparam logic [CODE_W-1:0] CMIN  = CODE_W'(CODE_MIN);
    localparam logic [CODE_W-1:0] CMAX  = CODE_W'(CODE_MAX);
    localparam logic [CODE_W-1:0] CRST  = CODE_W'(RESET_CODE);
    localparam logic [SEL_W:0]    NSRC  = (SEL_W+1)'(NUM_SRC);

    pllc_cfg_t w_cfg;
    logic      code_bad, sel_bad, retune_bad, reject, accept;

    always_comb begin
        w_cfg      = unpack_word(wdata);
        code_bad   = (w_cfg.code < CMIN) || (w_cfg.code > CMAX);
        sel_bad    = {1'b0, w_cfg.sel} >= NSRC;
        retune_bad = cfg_q.en && w_cfg.en && (w_cfg.code != cfg_q.code);
        reject     = wr_en && (code_bad || sel_bad || retune_bad);
        accept     = wr_en && !(code_bad || sel_bad || retune_bad);
        en_nxt     = accept ? w_cfg.en : cfg_q.en;
        restart    = accept && w_cfg.en && (!cfg_q.en || (w_cfg.sel != cfg_q.sel));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.en   <= 1'b0;
            cfg_q.code <= CRST;
            cfg_q.sel  <= '0;
        end else if (accept) begin
            cfg_q <= w_cfg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            err_q <= 1'b0;
        else if (reject)
            err_q <= 1'b1;
        else if (rd_en)
            err_q <= 1'b0;
    end

    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        reject |=> $stable(cfg_q)) else $error("rejected write changed config"); // R4
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.code >= CMIN) && (cfg_q.code <= CMAX)) else $error("illegal code held"); // R4
    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
        {1'b0, cfg_q.sel} < NSRC) else $error("undefined reference held"); // R5
    AST_NO_RETUNE: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.en && $past(cfg_q.en) && !$past(rst)) |-> (cfg_q.code == $past(cfg_q.code)))
        else $error("code changed while running"); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        reject |=> err_q) else $error("error flag not set"); // R7

endmodule

// File: rtl/pllc_lock_timer.sv
module pllc_lock_timer #(
    parameter int LOCK_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic en_nxt,
    input  logic restart,
    output logic ready_q
);

    localparam int CNT_W = (LOCK_CYCLES < 2) ? 1 : $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOCK_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en_nxt || restart) begin
            cnt_q   <= '0;
            ready_q <= 1'b0;
        end else if (!ready_q) begin
            if (cnt_q == LIMIT)
                ready_q <= 1'b1;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_RESTART_DROPS: assert property (@(posedge clk) disable iff (rst)
        restart |=> !ready_q) else $error("ready kept through restart"); // R11
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT) else $error("lock counter overran"); // R9
    AST_RISE_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_q) |-> (cnt_q == LIMIT)) else $error("ready rose early"); // R9

endmodule

// File: rtl/pllc_decode.sv
module pllc_decode
    import pllc_pkg::*;
#(
    parameter int MULT_W = 7
) (
    input  pllc_cfg_t         cfg,
    output logic [MULT_W-1:0] mult,
    output logic [SEL_W-1:0]  sel
);

    logic [MULT_W-1:0] scaled;

    always_comb begin
        scaled = MULT_W'({1'b0, cfg.code} + 1'b1) << 1;
        mult   = cfg.en ? scaled : MULT_W'(1);
        sel    = cfg.sel;
    end

endmodule

// File: rtl/pll_ctrl_reg.sv
module pll_ctrl_reg
    import pllc_pkg::*;
#(
    parameter int LOCK_CYCLES = 64,
    parameter int CODE_MIN    = 19,
    parameter int CODE_MAX    = 45,
    parameter int NUM_SRC     = 3,
    parameter int MULT_W      = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    input  logic              rd_en,
    output logic [31:0]       rdata,
    output logic              pll_on,
    output logic [MULT_W-1:0] mult_factor,
    output logic [1:0]        ref_sel,
    output logic              lock_ready
);

    localparam logic [MULT_W-1:0] MULT_LO = MULT_W'((CODE_MIN + 1) * 2);
    localparam logic [MULT_W-1:0] MULT_HI = MULT_W'((CODE_MAX + 1) * 2);

    pllc_cfg_t cfg_q;
    logic      en_nxt, restart, err_q, ready_q;
    logic [WORD_W-1:0] rdata_q;

    pllc_regfile #(
        .CODE_MIN  (CODE_MIN),
        .CODE_MAX  (CODE_MAX),
        .NUM_SRC   (NUM_SRC),
        .RESET_CODE(CODE_MIN)
    ) i_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wdata  (wdata),
        .rd_en  (rd_en),
        .cfg_q  (cfg_q),
        .en_nxt (en_nxt),
        .restart(restart),
        .err_q  (err_q)
    );

    pllc_lock_timer #(
        .LOCK_CYCLES(LOCK_CYCLES)
    ) i_lock (
        .clk    (clk),
        .rst    (rst),
        .en_nxt (en_nxt),
        .restart(restart),
        .ready_q(ready_q)
    );

    pllc_decode #(
        .MULT_W(MULT_W)
    ) i_dec (
        .cfg (cfg_q),
        .mult(mult_factor),
        .sel (ref_sel)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (rd_en)
            rdata_q <= pack_word(cfg_q, ready_q, err_q);
    end

    assign rdata      = rdata_q;
    assign pll_on     = cfg_q.en;
    assign lock_ready = ready_q;

    AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        lock_ready |-> pll_on) else $error("ready while off"); // R10
    AST_BYPASS_UNITY: assert property (@(posedge clk) disable iff (rst)
        !pll_on |-> (mult_factor == MULT_W'(1))) else $error("bypass factor wrong"); // R2
    AST_FACTOR_RANGE: assert property (@(posedge clk) disable iff (rst)
        pll_on |-> (mult_factor >= MULT_LO && mult_factor <= MULT_HI && !mult_factor[0]))
        else $error("factor out of band"); // R3

endmodule

// File: tb/test_pll_ctrl_reg.sv
module test_pll_ctrl_reg;

    localparam int LOCK = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic        pll_on;
    logic [6:0]  mult_factor;
    logic [1:0]  ref_sel;
    logic        lock_ready;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    pll_ctrl_reg #(.LOCK_CYCLES(LOCK)) i_pll_ctrl_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
        .rdata(rdata), .pll_on(pll_on), .mult_factor(mult_factor),
        .ref_sel(ref_sel), .lock_ready(lock_ready)
    );

    function automatic logic [31:0] mkw(input logic en, input int code, input int sel);
        logic [31:0] w;
        w = '0;
        w[31]    = en;
        w[29:24] = 6'(code);
        w[7:6]   = 2'(sel);
        return w;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // one cycle of stimulus, returns at the following falling edge
    task automatic cyc(input logic w, input logic [31:0] d, input logic r);
        wr_en = w; wdata = d; rd_en = r;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wr(input logic [31:0] d);
        cyc(1'b1, d, 1'b0);
    endtask

    task automatic rd(output logic [31:0] v);
        cyc(1'b0, '0, 1'b1);
        v = rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1", "pll_on", 32'(pll_on), 0);
        check("R1", "factor", 32'(mult_factor), 1);
        check("R1", "ready", 32'(lock_ready), 0);
        rd(v);
        check("R1", "reset word", v, 32'h1300_0000);
    endtask

    task automatic t_bypass();
        logic [31:0] v;
        wr(mkw(0, 30, 2));
        check("R2", "bypass factor", 32'(mult_factor), 1);
        check("R2", "bypass ref", 32'(ref_sel), 2);
        rd(v);
        check("R8", "read layout", v, 32'h1E00_0080);
    endtask

    task automatic t_enable_lock();
        logic [31:0] v;
        wr(mkw(1, 30, 2));
        check("R3", "factor code30", 32'(mult_factor), 62);
        idle(LOCK - 1);
        check("R9", "ready one edge early", 32'(lock_ready), 0);
        idle(1);
        check("R9", "ready on time", 32'(lock_ready), 1);
        rd(v);
        check("R8", "read with ready", v, mkw(1, 30, 2) | 32'h2);
    endtask

    task automatic t_retune_and_disable();
        wr(mkw(1, 19, 2));
        check("R6", "retune blocked", 32'(mult_factor), 62);
        check("R6", "ready kept", 32'(lock_ready), 1);
        wr(mkw(0, 45, 2));
        check("R10", "ready drops", 32'(lock_ready), 0);
        check("R6", "disable with new code", 32'(mult_factor), 1);
        wr(mkw(1, 45, 2));
        check("R3", "factor code45", 32'(mult_factor), 92);
    endtask

    task automatic t_errors();
        logic [31:0] v;
        rd(v);
        check("R7", "err from retune", v[0], 1);
        rd(v);
        check("R7", "err cleared", v[0], 0);
        wr(mkw(0, 18, 1));
        rd(v);
        check("R4", "code18 ignored", v & ~32'h2, mkw(1, 45, 2) | 32'h1);
        wr(mkw(0, 46, 0));
        check("R4", "code46 ignored on", 32'(pll_on), 1);
        rd(v);
        check("R4", "code46 err", v[0], 1);
        wr(mkw(1, 45, 3));
        check("R5", "sel3 ignored", 32'(ref_sel), 2);
        cyc(1'b1, mkw(1, 45, 3), 1'b1);
        check("R7", "read sees old err", v[0], 1);
        check("R7", "collision read old", rdata[0], 1);
        rd(v);
        check("R7", "set beats clear", v[0], 1);
        rd(v);
        check("R5", "err then clear", v[0], 0);
    endtask

    task automatic t_resel();
        idle(LOCK + 1);
        check("R11", "ready before resel", 32'(lock_ready), 1);
        wr(mkw(1, 45, 2));
        check("R11", "same-sel rewrite keeps ready", 32'(lock_ready), 1);
        wr(mkw(1, 45, 1));
        check("R11", "resel drops ready", 32'(lock_ready), 0);
        check("R2", "ref follows", 32'(ref_sel), 1);
        idle(LOCK - 1);
        check("R11", "relock early", 32'(lock_ready), 0);
        idle(1);
        check("R11", "relock on time", 32'(lock_ready), 1);
    endtask

    initial begin
        fork
            begin
                idle(3);
                rst = 1'b0;
                idle(1);
                t_reset();
                t_bypass();
                t_enable_lock();
                t_retune_and_disable();
                t_errors();
                t_resel();
            end
            begin
                repeat (5000) @(negedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule